// File: doc/BRIEF.md
# Domain-Range Data Hazard Detector

This block guards the entry of a pipeline. Every instruction is summarised by two resource masks. The read mask lists the resources whose contents the instruction consumes. The write mask lists the resources it may modify. Resources are working registers plus a condition-flags resource.

When an instruction is offered at fetch, the block intersects its masks with the masks of every instruction still in flight. It reports read-after-write, write-after-write and write-after-read conflicts on three separate flags. While any conflict is present, it holds the instruction back with a stall.

An instruction without conflicts is accepted into a small tracking shift register. This register mirrors the pipeline depth. It moves one stage per cycle, takes a bubble whenever nothing is accepted, and drops an instruction once it passes the last stage. A held instruction is therefore accepted as soon as the last conflicting instruction has drained.

Top module: `hazard_detector`

## Requirements
- R1: After reset every tracking stage is empty (`stage_busy` is all zero), and no hazard flag or stall is raised while nothing is offered.
- R2: `raw_hazard` is 1 when `fetch_valid` is 1 and the write mask of some occupied stage shares a set bit with `fetch_domain`.
- R3: `waw_hazard` is 1 when `fetch_valid` is 1 and the write mask of some occupied stage shares a set bit with `fetch_range`.
- R4: `war_hazard` is 1 when `fetch_valid` is 1 and the read mask of some occupied stage shares a set bit with `fetch_range`.
- R5: `stall` is the OR of the three hazard flags, and `accept` equals `fetch_valid` AND NOT `stall`. The flags and stall react in the same cycle as the fetch inputs, with no register between them.
- R6: With `fetch_valid` at 0, all three flags, `stall` and `accept` are 0, whatever the masks hold.
- R7: An accepted instruction occupies stage 0 (`stage_busy` bit 0) after the next clock edge. It moves up one stage per edge and is gone after DEPTH edges.
- R8: In a cycle without acceptance (stalled or idle), stage 0 holds a bubble after the next edge.
- R9: Mask bits 0 to 15 stand for registers r0 to r15 and bit 16 for the flags resource; the flags bit conflicts exactly like a register bit.
- R10: An instruction held by a conflict with an instruction accepted in the previous cycle stalls for exactly DEPTH cycles and is accepted in the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | An instruction is offered at fetch |
| fetch_domain | input | NRES | Read mask of the offered instruction |
| fetch_range | input | NRES | Write mask of the offered instruction |
| raw_hazard | output | 1 | Read-after-write conflict |
| waw_hazard | output | 1 | Write-after-write conflict |
| war_hazard | output | 1 | Write-after-read conflict |
| stall | output | 1 | Offered instruction is held |
| accept | output | 1 | Offered instruction enters the tracker |
| stage_busy | output | DEPTH | Occupancy of each tracking stage |

## Verification
The assertions assume that the fetch side keeps the same instruction on the inputs while `stall` is high. They also assume the masks are meaningful only when `fetch_valid` is set. The checks on occupancy flow rely only on the tracker, so they hold for any mask values. The stimulus drives all inputs on the falling edge. It keeps a held instruction unchanged until it is accepted, and it drains the tracker between table entries so that each entry sees exactly one prior instruction.

// File: rtl/hazard_detector.sv
module hazard_detector #(
  parameter int NRES  = 17,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [NRES-1:0]  fetch_domain,
  input  logic [NRES-1:0]  fetch_range,
  output logic             raw_hazard,
  output logic             waw_hazard,
  output logic             war_hazard,
  output logic             stall,
  output logic             accept,
  output logic [DEPTH-1:0] stage_busy
);

  logic [DEPTH-1:0] vld_q;
  logic [NRES-1:0]  rd_q [DEPTH];
  logic [NRES-1:0]  wr_q [DEPTH];
  logic [DEPTH-1:0] raw_s, waw_s, war_s;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      raw_s[i] = vld_q[i] && |(wr_q[i] & fetch_domain);
      waw_s[i] = vld_q[i] && |(wr_q[i] & fetch_range);
      war_s[i] = vld_q[i] && |(rd_q[i] & fetch_range);
    end
  end

  assign raw_hazard = fetch_valid && |raw_s;
  assign waw_hazard = fetch_valid && |waw_s;
  assign war_hazard = fetch_valid && |war_s;
  assign stall      = raw_hazard || waw_hazard || war_hazard;
  assign accept     = fetch_valid && !stall;
  assign stage_busy = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        rd_q[i] <= '0;
        wr_q[i] <= '0;
      end
    end else begin
      vld_q[0] <= accept;
      rd_q[0]  <= accept ? fetch_domain : '0;
      wr_q[0]  <= accept ? fetch_range  : '0;
      for (int i = 1; i < DEPTH; i++) begin
        vld_q[i] <= vld_q[i-1];
        rd_q[i]  <= rd_q[i-1];
        wr_q[i]  <= wr_q[i-1];
      end
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vld_q == '0)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (!stall && !accept)); // R6
  AST_WAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    waw_hazard |-> !accept); // R3
  AST_ENTER_STAGE0: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> vld_q[0]); // R7
  AST_BUBBLE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !vld_q[0]); // R8

  for (genvar g = 1; g < DEPTH; g++) begin : g_adv
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[g-1] |=> vld_q[g]); // R7
    AST_NO_GHOST: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q[g-1] |=> !vld_q[g]); // R8
  end

endmodule

// File: tb/hazard_detector_tb.sv
module hazard_detector_tb;
  localparam int NRES  = 17;
  localparam int DEPTH = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic fetch_valid = 0;
  logic [NRES-1:0] fetch_domain = '0, fetch_range = '0;
  logic raw_hazard, waw_hazard, war_hazard, stall, accept;
  logic [DEPTH-1:0] stage_busy;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  hazard_detector #(.NRES(NRES), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .fetch_domain(fetch_domain), .fetch_range(fetch_range),
    .raw_hazard(raw_hazard), .waw_hazard(waw_hazard), .war_hazard(war_hazard),
    .stall(stall), .accept(accept), .stage_busy(stage_busy));

  // entry: A read, A write, B read, B write, expected {raw, waw, war}
  localparam logic [70:0] VEC [8] = '{
    {17'h00004, 17'h00002, 17'h00002, 17'h00008, 3'b100},
    {17'h00004, 17'h00002, 17'h00010, 17'h00002, 3'b010},
    {17'h00004, 17'h00002, 17'h00010, 17'h00004, 3'b001},
    {17'h00004, 17'h00002, 17'h00010, 17'h00020, 3'b000},
    {17'h00001, 17'h10000, 17'h10000, 17'h00008, 3'b100},
    {17'h00006, 17'h00002, 17'h00002, 17'h00006, 3'b111},
    {17'h0FFFF, 17'h1FFFF, 17'h00000, 17'h00000, 3'b000},
    {17'h10000, 17'h00001, 17'h00100, 17'h10000, 3'b001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [NRES-1:0] d, input logic [NRES-1:0] r);
    @(negedge clk);
    fetch_valid = v; fetch_domain = d; fetch_range = r;
    #2;
  endtask

  task automatic drain();
    drive(1'b0, '0, '0);
    repeat (DEPTH + 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 busy in reset", stage_busy, 0);
    rst_n = 1;
    drive(1'b0, '0, '0);
    chk("R1 busy after reset", stage_busy, 0);
    chk("R1 stall idle", stall, 0);

    // R6: masks present but no valid
    drive(1'b0, 17'h1FFFF, 17'h1FFFF);
    chk("R6 flags without valid", {raw_hazard, waw_hazard, war_hazard, stall, accept}, 0);

    // table of pairs: A accepted, B checked next cycle (R2 R3 R4 R5, entries 5 and 8 exercise R9)
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, VEC[k][70:54], VEC[k][53:37]);
      chk("R5 accept of first", accept, 1);
      drive(1'b1, VEC[k][36:20], VEC[k][19:3]);
      chk("R2 raw", raw_hazard, VEC[k][2]);
      chk("R3 waw", waw_hazard, VEC[k][1]);
      chk("R4 war", war_hazard, VEC[k][0]);
      chk("R5 stall", stall, |VEC[k][2:0]);
      chk("R5 accept", accept, ~|VEC[k][2:0]);
      if (k == 4 || k == 7) chk("R9 flags bit", stall, 1);
      drain();
    end

    // R7: occupancy walks through the tracker
    drive(1'b1, 17'h00001, 17'h00002);
    drive(1'b0, '0, '0);
    chk("R7 stage0", stage_busy, 4'b0001);
    @(negedge clk); #2; chk("R7 stage1", stage_busy, 4'b0010);
    @(negedge clk); #2; chk("R7 stage2", stage_busy, 4'b0100);
    @(negedge clk); #2; chk("R7 stage3", stage_busy, 4'b1000);
    @(negedge clk); #2; chk("R7 retired", stage_busy, 4'b0000);

    // R10 and R8: held instruction waits DEPTH cycles, bubbles meanwhile
    drive(1'b1, 17'h00004, 17'h00008);
    for (int c = 0; c < DEPTH; c++) begin
      drive(1'b1, 17'h00008, 17'h00001);
      chk("R10 stalled", stall, 1);
      if (c > 0) chk("R8 bubble stage0", stage_busy[0], 0);
    end
    drive(1'b1, 17'h00008, 17'h00001);
    chk("R10 accepted after drain", accept, 1);
    drive(1'b0, '0, '0);
    chk("R7 accepted entered", stage_busy, 4'b0001);
    drain();

    // R4 against an older stage only
    drive(1'b1, 17'h00800, 17'h00000);
    drive(1'b0, '0, '0);
    drive(1'b0, '0, '0);
    drive(1'b1, 17'h00000, 17'h00800);
    chk("R4 war deep stage", war_hazard, 1);
    chk("R2 no raw deep", raw_hazard, 0);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule